// File: doc/BRIEF.md
# Serial Channel External/Status Change Interrupt Latch

This block watches the modem-control and line-status inputs of a two-channel serial controller and turns a change on any of them into an interrupt request. Each channel has eight status bits. Three of them come from package pins (clear-to-send, carrier detect, sync/hunt) and are resynchronised before use. The other five come from synchronous logic inside the controller: break/abort, transmit underrun/end-of-message, transmitter buffer empty, baud generator zero count and receive character available. The host sets a per-source enable mask for each channel. Any rising or falling edge on an enabled source latches a request.

While a request is pending, the edge-sensitive bits of the channel's status byte are frozen at the values captured when the change was seen. The host can therefore read what caused the interrupt, even if the line has already moved on. The two buffer flags stay live. A reset-status command from the host reopens the latch. If a source moved while the latch was frozen, the reopened latch compares against the held value, so that change raises a fresh request at once and is not lost. The pending flags are reported at fixed bit positions of an interrupt-pending byte. A shared master enable gates the combined request line.

Top module: `extstat_latch`

## Requirements
- R1: After reset all enables and masks are cleared, no request is pending, `irq_o` is 0 and `ip_o` is 0.
- R2: The status byte of each channel has this layout: bit 7 break/abort, bit 6 transmit underrun/EOM, bit 5 CTS, bit 4 sync/hunt, bit 3 DCD, bit 2 transmit buffer empty, bit 1 zero count, bit 0 receive character available. With no request pending, every bit follows the conditioned input.
- R3: Bits 5, 4 and 3 pass through a two-flop synchronizer and reach the status byte after the second rising clock edge following the input change. All other bits reach it combinationally.
- R4: A write to address 15 sets the channel's source enables for bits 7, 6, 5, 4, 3 and 1. A rising or a falling transition of an enabled conditioned source sets the channel's pending flag on the next clock edge.
- R5: A transition of a source whose enable bit is 0 sets no pending flag.
- R6: While a channel is pending, status bits 7, 6, 5, 4, 3 and 1 hold the values captured at the change. Bits 2 and 0 stay live.
- R7: A write to address 0 whose data bits 5:3 equal 3'b010 (code 0x10) clears the pending flag of the addressed channel. Other command codes leave it unchanged.
- R8: After a clear the latch reopens. A conditioned source that differs from the held value on an enabled bit, including a change made while frozen, sets the flag again one cycle later. With no difference, the flag stays clear.
- R9: `irq_o` is 1 exactly when the master enable (address 9, data bit 3, shared by both channels) is set and at least one bit of `ip_o` is 1.
- R10: `ip_o` bit 3 is channel A pending AND channel A's status-interrupt enable (address 1, data bit 0). Bit 0 is the same for channel B. All other bits are 0.
- R11: `wr_ch` (0 = A, 1 = B) selects the channel for addresses 0, 1 and 15. A command or enable on one channel leaves the other channel unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel select for the write (0 = A, 1 = B) |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| stat_a_i | input | 8 | Channel A raw status sources, status-byte layout |
| stat_b_i | input | 8 | Channel B raw status sources, status-byte layout |
| rr0_a_o | output | 8 | Channel A status byte |
| rr0_b_o | output | 8 | Channel B status byte |
| ip_o | output | 6 | Interrupt-pending byte (A at bit 3, B at bit 0) |
| irq_o | output | 1 | Combined external/status interrupt request |

## Verification
The bench targets the following corner cases.

- A line that toggles while the latch is frozen, followed by a clear. A design that resamples on reopening would swallow this change and never interrupt again.
- Falling edges. A rising-edge-only detector stays silent on them.
- Edges on disabled sources. A design that ignores the mask would raise spurious requests.
- Command codes other than 0x10, and clears aimed at the other channel. A loose decoder would drop a request that should stay pending.
- The two-cycle path through the synchronizer. A status byte that moves one cycle early or late on bits 5 to 3 shows up as a mismatch with the per-cycle model.
- The live bits 2 and 0 while frozen. A design that freezes the whole byte would stop showing buffer activity.

// File: rtl/extstat_pkg.sv
package extstat_pkg;
   localparam int STAT_W = 8;
   localparam int NUM_CH = 2;

   localparam logic [3:0] REG_CMD    = 4'd0;
   localparam logic [3:0] REG_IMODE  = 4'd1;
   localparam logic [3:0] REG_MASTER = 4'd9;
   localparam logic [3:0] REG_SRC_EN = 4'd15;

   localparam logic [2:0] CMD_CLR_STAT = 3'b010;
   localparam int CMD_LO  = 3;
   localparam int CMD_HI  = 5;
   localparam int SIE_BIT = 0;
   localparam int MIE_BIT = 3;

   // bits that are edge-watched and frozen, and bits that always track
   localparam logic [STAT_W-1:0] EDGE_BITS = 8'hFA;
   localparam logic [STAT_W-1:0] LIVE_BITS = 8'h05;

   localparam int IP_W     = 6;
   localparam int IP_A_BIT = 3;
   localparam int IP_B_BIT = 0;
endpackage

// File: rtl/extstat_sync.sv
module extstat_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad
      $error("extstat_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {sr_q[STAGES-2:0], d_i};
   end

   assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/extstat_chan.sv
module extstat_chan
   import extstat_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [STAT_W-1:0] ASYNC_MASK  = 8'h38
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] raw_i,
   input  logic [STAT_W-1:0] mask_i,
   input  logic              clr_i,
   output logic [STAT_W-1:0] rr0_o,
   output logic              pend_o
);
   logic [STAT_W-1:0] cond;
   logic [STAT_W-1:0] held_q;
   logic              pend_q;
   logic              hit;

   for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      if (ASYNC_MASK[b]) begin : g_sync
         extstat_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (raw_i[b]),
            .q_o  (cond[b])
         );
      end else begin : g_direct
         assign cond[b] = raw_i[b];
      end
   end

   assign hit = |((cond ^ held_q) & mask_i & EDGE_BITS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
         pend_q <= 1'b0;
      end else if (pend_q) begin
         if (clr_i) pend_q <= 1'b0;
      end else begin
         held_q <= cond;
         if (hit) pend_q <= 1'b1;
      end
   end

   assign rr0_o  = ((pend_q ? held_q : cond) & EDGE_BITS) | (cond & LIVE_BITS);
   assign pend_o = pend_q;

   AST_FROZEN_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr_i) |=> $stable(rr0_o & EDGE_BITS)) else $error("frozen bits moved"); // R6
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && clr_i) |=> !pend_q) else $error("clear ignored"); // R7
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !hit) |=> !pend_q) else $error("pending without change"); // R5
endmodule

// File: rtl/extstat_latch.sv
module extstat_latch
   import extstat_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [STAT_W-1:0] ASYNC_MASK  = 8'h38
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ch,
   input  logic [3:0]        wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [STAT_W-1:0] stat_a_i,
   input  logic [STAT_W-1:0] stat_b_i,
   output logic [STAT_W-1:0] rr0_a_o,
   output logic [STAT_W-1:0] rr0_b_o,
   output logic [IP_W-1:0]   ip_o,
   output logic              irq_o
);
   logic [STAT_W-1:0] raw    [NUM_CH];
   logic [STAT_W-1:0] rr0    [NUM_CH];
   logic [STAT_W-1:0] srcen_q[NUM_CH];
   logic [NUM_CH-1:0] sie_q;
   logic [NUM_CH-1:0] clr;
   logic [NUM_CH-1:0] pend;
   logic              mie_q;
   logic              is_clr_cmd;

   assign raw[0]  = stat_a_i;
   assign raw[1]  = stat_b_i;
   assign rr0_a_o = rr0[0];
   assign rr0_b_o = rr0[1];

   assign is_clr_cmd = wr_en && (wr_addr == REG_CMD) &&
                       (wr_data[CMD_HI:CMD_LO] == CMD_CLR_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) srcen_q[i] <= '0;
         sie_q <= '0;
         mie_q <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_IMODE:  sie_q[wr_ch]   <= wr_data[SIE_BIT];
            REG_MASTER: mie_q          <= wr_data[MIE_BIT];
            REG_SRC_EN: srcen_q[wr_ch] <= wr_data & EDGE_BITS;
            default: ;
         endcase
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign clr[c] = is_clr_cmd && (wr_ch == 1'(c));
      extstat_chan #(
         .SYNC_STAGES(SYNC_STAGES),
         .ASYNC_MASK (ASYNC_MASK)
      ) i_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .raw_i (raw[c]),
         .mask_i(srcen_q[c]),
         .clr_i (clr[c]),
         .rr0_o (rr0[c]),
         .pend_o(pend[c])
      );
   end

   always_comb begin
      ip_o           = '0;
      ip_o[IP_A_BIT] = pend[0] & sie_q[0];
      ip_o[IP_B_BIT] = pend[1] & sie_q[1];
   end

   assign irq_o = mie_q & (|ip_o);

   AST_CLR_A_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_clr_cmd && !wr_ch && ip_o[IP_A_BIT]) |=> !ip_o[IP_A_BIT]) else $error("A not cleared"); // R7
   AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_MASTER && !wr_data[MIE_BIT]) |=> !irq_o) else $error("irq with master off"); // R9
endmodule

// File: tb/test_extstat_latch.sv
module test_extstat_latch;
   localparam int          STG = 2;
   localparam logic [7:0]  AM  = 8'h38;
   localparam logic [7:0]  EB  = 8'hFA;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_ch = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] stat_a = '0;
   logic [7:0] stat_b = '0;
   logic [7:0] rr0_a, rr0_b;
   logic [5:0] ip;
   logic       irq;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   extstat_latch i_extstat_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .stat_a_i(stat_a), .stat_b_i(stat_b),
      .rr0_a_o(rr0_a), .rr0_b_o(rr0_b), .ip_o(ip), .irq_o(irq)
   );

   // reference model
   logic [7:0] hq_a[$];
   logic [7:0] hq_b[$];
   logic [7:0] m_held[2];
   logic [7:0] m_mask[2];
   bit         m_pend[2];
   bit         m_sie[2];
   bit         m_mie;
   bit         m_ok = 0;

   function automatic logic [7:0] s_of(int ch);
      logic [7:0] cur;
      logic [7:0] dly;
      cur = (ch == 0) ? stat_a : stat_b;
      dly = (ch == 0) ? hq_a[STG-1] : hq_b[STG-1];
      return (cur & ~AM) | (dly & AM);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hq_a.delete(); hq_b.delete();
         for (int i = 0; i < STG; i++) begin hq_a.push_back(8'h00); hq_b.push_back(8'h00); end
         for (int c = 0; c < 2; c++) begin
            m_held[c] = 0; m_mask[c] = 0; m_pend[c] = 0; m_sie[c] = 0;
         end
         m_mie = 0;
         m_ok = 1;
      end else begin
         for (int c = 0; c < 2; c++) begin
            logic [7:0] s;
            bit hitc, clrc;
            s = s_of(c);
            hitc = ((s ^ m_held[c]) & m_mask[c]) != 0;
            clrc = wr_en && wr_addr == 0 && int'(wr_ch) == c && wr_data[5:3] == 3'b010;
            if (m_pend[c]) begin
               if (clrc) m_pend[c] = 0;
            end else begin
               m_held[c] = s;
               if (hitc) m_pend[c] = 1;
            end
         end
         if (wr_en) begin
            if (wr_addr == 1)  m_sie[wr_ch]  = wr_data[0];
            if (wr_addr == 9)  m_mie         = wr_data[3];
            if (wr_addr == 15) m_mask[wr_ch] = wr_data & EB;
         end
         hq_a.push_front(stat_a); void'(hq_a.pop_back());
         hq_b.push_front(stat_b); void'(hq_b.pop_back());
      end
   end

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every clock
   always @(posedge clk) begin
      #5;
      if (rst_n && m_ok) begin
         logic [7:0] ea, eb2;
         logic [5:0] eip;
         ea  = ((m_pend[0] ? m_held[0] : s_of(0)) & EB) | (s_of(0) & ~EB);
         eb2 = ((m_pend[1] ? m_held[1] : s_of(1)) & EB) | (s_of(1) & ~EB);
         eip = {2'b00, m_pend[0] & m_sie[0], 2'b00, m_pend[1] & m_sie[1]};
         chk("R6 model rr0_a", rr0_a, ea);
         chk("R6 model rr0_b", rr0_b, eb2);
         chk("R10 model ip", {2'b00, ip}, {2'b00, eip});
         chk("R9 model irq", {7'd0, irq}, {7'd0, m_mie && eip != 0});
      end
   end

   task automatic smp();
      @(posedge clk); #5;
   endtask

   task automatic wr(bit ch, logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_ch = ch; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #1ms;
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      smp();
      chk("R1 ip after reset", {2'b00, ip}, 8'h00);
      chk("R1 irq after reset", {7'd0, irq}, 8'h00);
      chk("R1 rr0_a after reset", rr0_a, 8'h00);

      // R2: direct bits show at once
      @(negedge clk); stat_a = 8'hC5;
      smp(); chk("R2 rr0_a direct bits", rr0_a, 8'hC5);
      // R3: synchronised bits lag two edges
      @(negedge clk); stat_a = 8'hFF;
      smp(); chk("R3 rr0_a after one edge", rr0_a, 8'hC7);
      smp(); chk("R3 rr0_a after two edges", rr0_a, 8'hFF);
      @(negedge clk); stat_a = 8'h00;
      repeat (3) @(negedge clk);

      wr(0, 15, 8'h20);
      wr(0, 1, 8'h01);
      wr(0, 9, 8'h08);
      // R4: rising CTS
      @(negedge clk); stat_a = 8'h20;
      smp(); smp(); chk("R4 not yet pending", {2'b00, ip}, 8'h00);
      smp(); chk("R4 pending on rise", {2'b00, ip}, 8'h08);
      chk("R4 irq on rise", {7'd0, irq}, 8'h01);
      // R6: freeze while line moves
      @(negedge clk); stat_a = 8'h01;
      smp(); smp(); smp(); chk("R6 frozen CTS, live bit0", rr0_a, 8'h21);
      // R7: other code no effect, other channel clear no effect
      wr(0, 0, 8'h18);
      chk("R7 other code keeps pending", {2'b00, ip}, 8'h08);
      wr(1, 0, 8'h10);
      chk("R11 clear on B keeps A", {2'b00, ip}, 8'h08);
      wr(0, 0, 8'h10);
      chk("R7 cleared", {2'b00, ip}, 8'h00);
      smp(); chk("R8 change during freeze re-raises", {2'b00, ip}, 8'h08);
      chk("R4 falling edge captured", rr0_a, 8'h01);
      wr(0, 0, 8'h10);
      smp(); smp(); smp(); chk("R8 stays clear without change", {2'b00, ip}, 8'h00);
      // R5: disabled DCD
      @(negedge clk); stat_a = 8'h09;
      repeat (4) smp();
      chk("R5 disabled source ignored", {2'b00, ip}, 8'h00);
      chk("R5 status still live", rr0_a, 8'h09);
      // R9: master gating
      @(negedge clk); stat_a = 8'h29;
      repeat (3) smp();
      chk("R9 irq with master on", {7'd0, irq}, 8'h01);
      wr(0, 9, 8'h00);
      chk("R9 irq off with master off", {7'd0, irq}, 8'h00);
      chk("R10 ip independent of master", {2'b00, ip}, 8'h08);
      wr(0, 9, 8'h08);
      wr(0, 1, 8'h00);
      chk("R10 ip gated by channel enable", {2'b00, ip}, 8'h00);
      wr(0, 1, 8'h01);
      wr(0, 0, 8'h10);
      // R10 / R11: channel B
      wr(1, 15, 8'h80);
      wr(1, 1, 8'h01);
      @(negedge clk); stat_b = 8'h80; stat_a = 8'hA9;
      smp(); chk("R10 channel B at bit 0", {2'b00, ip}, 8'h01);
      smp(); chk("R11 A mask excludes break", {2'b00, ip}, 8'h01);
      wr(1, 0, 8'h10);
      smp(); chk("R11 B cleared", {2'b00, ip}, 8'h00);

      // mixed stimulus, checked by the model every clock
      for (int n = 0; n < 600; n++) begin
         @(negedge clk);
         if (($urandom % 4) == 0) stat_a = stat_a ^ (8'd1 << ($urandom % 8));
         if (($urandom % 4) == 0) stat_b = stat_b ^ (8'd1 << ($urandom % 8));
         wr_en = (($urandom % 5) == 0);
         wr_ch = 1'($urandom % 2);
         case ($urandom % 4)
            0: wr_addr = 4'd0;
            1: wr_addr = 4'd1;
            2: wr_addr = 4'd9;
            default: wr_addr = 4'd15;
         endcase
         wr_data = 8'($urandom);
      end
      @(negedge clk); wr_en = 0;
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule